// File: doc/BRIEF.md
# HDLC Serial Frame Receiver

This block turns a flag-delimited serial bit stream into bytes. It waits for an opening flag before it assembles anything. Inside a frame it deletes the zero that follows every run of five ones, and it builds bytes least significant bit first. It checks a 16-bit frame check sequence and delivers each data byte together with a two-bit status code that marks where the byte sits in the packet and whether the packet was good. The FCS bytes themselves are never delivered. The same run-of-ones tracking reports three line conditions. Seven ones inside a frame are an abort. A zero, then exactly seven ones, then a zero is a go-ahead. Fifteen or more ones mean the channel is idle.

Serial bits arrive on a valid/ready pair. A bit is taken on a clock edge where `ser_valid` and `ser_ready` are both high. Bytes leave on a second valid/ready pair that feeds a receive FIFO. A byte transfers on an edge where `byte_valid` and `byte_ready` are both high. While a byte waits, `byte_valid`, `byte_data` and `byte_stat` hold steady. Back-pressure is carried straight through the block: `ser_ready` is low exactly while a byte is waiting and `byte_ready` is low, so no byte is ever lost. When `rx_en` is low, bits are still taken but they have no effect, and the block drops any partial frame.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: After synchronous reset, `byte_valid`, `line_idle` and `go_ahead` are 0 and `ser_ready` is 1.
- R2: No byte is delivered until an opening flag 0x7E has been received; in arrival order the flag is 0,1,1,1,1,1,1,0.
- R3: Inside a frame, a zero that follows five consecutive ones is removed, so data bytes such as 0xFF and 0x7E come through intact.
- R4: Data bits are assembled least significant bit first. The first byte delivered for a frame carries status 2'b01, and the bytes after it carry 2'b00.
- R5: On a closing flag, the last data byte carries status 2'b10 if the FCS is good. The FCS is CRC-16 with reflected polynomial 0x8408, preset 0xFFFF, sent complemented with the low byte first, and a good frame leaves a residue of 0xF0B8. The two FCS bytes are not delivered. One flag may both close a frame and open the next.
- R6: On a closing flag with a wrong FCS, or with a bit count that is not a whole number of bytes, the last data byte carries status 2'b11.
- R7: A frame with fewer than four bytes between its flags (fewer than two data bytes plus FCS) delivers nothing.
- R8: Seven consecutive ones inside a frame that has already delivered a byte deliver the oldest held byte with status 2'b11, and the block then hunts for a flag. Trailing ones of the last data bits count toward the seven.
- R9: `go_ahead` pulses for one cycle after the closing zero of the pattern zero, seven ones, zero is taken. Runs of six or eight ones do not raise it.
- R10: `line_idle` rises in the cycle after the fifteenth consecutive one is taken, and falls after the next zero is taken.
- R11: `ser_ready` equals not `byte_valid` or `byte_ready`. A byte that is not accepted holds its data and status stable.
- R12: While `rx_en` is low, bits have no effect, any frame in progress is dropped, and `line_idle` and `go_ahead` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_en | input | 1 | Receiver enable |
| ser_valid | input | 1 | Serial bit valid |
| ser_ready | output | 1 | Serial bit accepted |
| ser_bit | input | 1 | Serial data bit |
| byte_valid | output | 1 | Byte ready for FIFO write |
| byte_ready | input | 1 | FIFO accepts byte |
| byte_data | output | 8 | Received data byte |
| byte_stat | output | 2 | 00 body, 01 first, 10 last good, 11 last bad or aborted |
| line_idle | output | 1 | Fifteen or more ones received |
| go_ahead | output | 1 | One-cycle go-ahead pulse |

## Verification
The bench sends data bytes made of ones, and data bytes equal to the flag value. A receiver that got zero deletion wrong would either break those bytes or close the frame early. Frames of zero and one data byte check that the FCS holding never leaks a byte. Frames that share a flag check that the closing flag reopens the next frame. An abort is placed so that it depends on ones carried over from the last data byte, which separates an abort from a late flag. Runs of six, seven and eight ones check that the go-ahead does not fire on flags or long runs. A stall held for many cycles checks that serial input stops and the waiting byte does not change.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam int BYTE_W = 8;
  localparam logic [15:0] CRC_POLY_R = 16'h8408;
  localparam logic [15:0] CRC_PRESET = 16'hFFFF;
  localparam logic [15:0] CRC_GOOD   = 16'hF0B8;

  typedef enum logic [1:0] {
    ST_BODY    = 2'b00,
    ST_FIRST   = 2'b01,
    ST_END_OK  = 2'b10,
    ST_END_BAD = 2'b11
  } rx_stat_e;

  function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [BYTE_W-1:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < BYTE_W; i++) begin
      if (r[0] ^ b[i]) r = (r >> 1) ^ CRC_POLY_R;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/hdlc_rx_linecode.sv
module hdlc_rx_linecode #(
  parameter int IDLE_RUN = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic step,
  input  logic bit_i,
  output logic data_o,
  output logic flag_o,
  output logic abort_o,
  output logic idle_o,
  output logic ga_o
);
  localparam int CW = $clog2(IDLE_RUN + 1);

  logic [CW-1:0] ones_q, ones_nxt;
  logic          zero_seen_q, idle_q, ga_q, ga_ev;

  always_comb begin
    data_o  = bit_i ? (ones_q < CW'(6)) : (ones_q < CW'(5));
    flag_o  = !bit_i && (ones_q == CW'(6)) && zero_seen_q;
    abort_o = bit_i && (ones_q == CW'(6));
    ga_ev   = !bit_i && (ones_q == CW'(7)) && zero_seen_q;
    if (!bit_i)                        ones_nxt = '0;
    else if (ones_q == CW'(IDLE_RUN))  ones_nxt = ones_q;
    else                               ones_nxt = ones_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      ones_q      <= '0;
      zero_seen_q <= 1'b0;
      idle_q      <= 1'b0;
      ga_q        <= 1'b0;
    end else begin
      ga_q <= step && ga_ev;
      if (step) begin
        ones_q      <= ones_nxt;
        idle_q      <= bit_i && (ones_nxt == CW'(IDLE_RUN));
        zero_seen_q <= zero_seen_q || !bit_i;
      end
    end
  end

  assign idle_o = idle_q;
  assign ga_o   = ga_q;

  p_ga_one_shot_r9: assert property (@(posedge clk) disable iff (rst) ga_q |=> !ga_q);
  p_idle_drop_r10: assert property (@(posedge clk) disable iff (rst) (en && step && !bit_i) |=> !idle_q);
  p_disabled_quiet_r12: assert property (@(posedge clk) disable iff (rst) !en |=> (!idle_q && !ga_q));
endmodule

// File: rtl/hdlc_rx_crc16.sv
module hdlc_rx_crc16
  import hdlc_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              init,
  input  logic              upd,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              good_o
);
  logic [15:0] crc_q;

  always_ff @(posedge clk) begin
    if (rst || init) crc_q <= CRC_PRESET;
    else if (upd)    crc_q <= crc16_byte(crc_q, byte_i);
  end

  assign good_o = (crc_q == CRC_GOOD);
endmodule

// File: rtl/hdlc_rx_framer.sv
module hdlc_rx_framer
  import hdlc_rx_pkg::*;
#(
  parameter int FCS_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              step,
  input  logic              bit_i,
  input  logic              data_ev,
  input  logic              flag_ev,
  input  logic              abort_ev,
  input  logic              crc_good,
  output logic              crc_init,
  output logic              crc_upd,
  output logic [BYTE_W-1:0] asm_o,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic [1:0]        out_stat
);
  localparam int HOLD  = FCS_BYTES + 1;
  localparam int CNT_W = $clog2(HOLD + 1);
  localparam int BIT_W = $clog2(BYTE_W);

  logic              in_frame_q, started_q;
  logic [BIT_W-1:0]  bitcnt_q;
  logic [BYTE_W-1:0] shreg_q;
  logic [BYTE_W-1:0] hold_q [HOLD];
  logic [CNT_W-1:0]  cnt_q;
  logic              byte_done, close_ev, kill_ev, push_out, emit, aligned;
  rx_stat_e          emit_stat;

  always_comb begin
    asm_o     = {bit_i, shreg_q[BYTE_W-1:1]};
    aligned   = (bitcnt_q == BIT_W'(BYTE_W - 1));
    byte_done = step && in_frame_q && data_ev && aligned;
    close_ev  = step && in_frame_q && flag_ev && started_q;
    kill_ev   = step && in_frame_q && abort_ev && started_q;
    push_out  = byte_done && (cnt_q == CNT_W'(HOLD));
    emit      = push_out || close_ev || kill_ev;
    if (push_out)                          emit_stat = started_q ? ST_BODY : ST_FIRST;
    else if (close_ev && crc_good && aligned) emit_stat = ST_END_OK;
    else                                   emit_stat = ST_END_BAD;
    crc_init  = step && flag_ev;
    crc_upd   = byte_done;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_stat   <= '0;
      in_frame_q <= 1'b0;
      started_q  <= 1'b0;
      bitcnt_q   <= '0;
      shreg_q    <= '0;
      cnt_q      <= '0;
      for (int i = 0; i < HOLD; i++) hold_q[i] <= '0;
    end else begin
      if (emit) begin
        out_valid <= 1'b1;
        out_data  <= hold_q[0];
        out_stat  <= emit_stat;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      if (!en) begin
        in_frame_q <= 1'b0;
      end else if (step) begin
        if (flag_ev) begin
          in_frame_q <= 1'b1;
          started_q  <= 1'b0;
          bitcnt_q   <= '0;
          cnt_q      <= '0;
        end else if (abort_ev) begin
          in_frame_q <= 1'b0;
        end else if (data_ev && in_frame_q) begin
          shreg_q  <= asm_o;
          bitcnt_q <= bitcnt_q + 1'b1;
          if (aligned) begin
            if (cnt_q == CNT_W'(HOLD)) begin
              for (int i = 0; i < HOLD - 1; i++) hold_q[i] <= hold_q[i+1];
              hold_q[HOLD-1] <= asm_o;
              started_q      <= 1'b1;
            end else begin
              hold_q[cnt_q] <= asm_o;
              cnt_q         <= cnt_q + 1'b1;
            end
          end
        end
      end
    end
  end

  p_hold_stable_r11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_stat)));
  p_short_silent_r7: assert property (@(posedge clk) disable iff (rst)
    (step && flag_ev && in_frame_q && !started_q && !out_valid) |=> !out_valid);
  p_abort_hunt_r8: assert property (@(posedge clk) disable iff (rst)
    (en && step && abort_ev) |=> !in_frame_q);
endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
#(
  parameter int IDLE_RUN  = 15,
  parameter int FCS_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              ser_valid,
  output logic              ser_ready,
  input  logic              ser_bit,
  output logic              byte_valid,
  input  logic              byte_ready,
  output logic [BYTE_W-1:0] byte_data,
  output logic [1:0]        byte_stat,
  output logic              line_idle,
  output logic              go_ahead
);
  logic              step, data_ev, flag_ev, abort_ev;
  logic              crc_good, crc_init, crc_upd;
  logic [BYTE_W-1:0] asm_byte;

  assign ser_ready = !byte_valid || byte_ready;
  assign step      = ser_valid && ser_ready && rx_en;

  hdlc_rx_linecode #(.IDLE_RUN(IDLE_RUN)) u_line (
    .clk(clk), .rst(rst), .en(rx_en), .step(step), .bit_i(ser_bit),
    .data_o(data_ev), .flag_o(flag_ev), .abort_o(abort_ev),
    .idle_o(line_idle), .ga_o(go_ahead)
  );

  hdlc_rx_crc16 u_crc (
    .clk(clk), .rst(rst), .init(crc_init), .upd(crc_upd),
    .byte_i(asm_byte), .good_o(crc_good)
  );

  hdlc_rx_framer #(.FCS_BYTES(FCS_BYTES)) u_frm (
    .clk(clk), .rst(rst), .en(rx_en), .step(step), .bit_i(ser_bit),
    .data_ev(data_ev), .flag_ev(flag_ev), .abort_ev(abort_ev),
    .crc_good(crc_good), .crc_init(crc_init), .crc_upd(crc_upd), .asm_o(asm_byte),
    .out_ready(byte_ready), .out_valid(byte_valid), .out_data(byte_data), .out_stat(byte_stat)
  );
endmodule

// File: tb/hdlc_rx_deframer_tb_top.sv
module hdlc_rx_deframer_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_en = 1'b0;
  logic       ser_valid = 1'b0;
  logic       ser_bit = 1'b0;
  logic       byte_ready = 1'b0;
  logic       ser_ready, byte_valid, line_idle, go_ahead;
  logic [7:0] byte_data;
  logic [1:0] byte_stat;

  int n_chk = 0, n_bad = 0, ready_mode = 2, tx_ones = 0, ga_cnt = 0;
  logic idle_last, ga_last;
  logic [9:0] exp_q[$], got_q[$];
  logic [7:0] buf_b [16];

  always #4 clk = ~clk;

  hdlc_rx_deframer dut_i (
    .clk(clk), .rst(rst), .rx_en(rx_en), .ser_valid(ser_valid), .ser_ready(ser_ready),
    .ser_bit(ser_bit), .byte_valid(byte_valid), .byte_ready(byte_ready),
    .byte_data(byte_data), .byte_stat(byte_stat), .line_idle(line_idle), .go_ahead(go_ahead)
  );

  always @(negedge clk) begin
    if (ready_mode == 0)      byte_ready = (($urandom % 4) != 0);
    else if (ready_mode == 1) byte_ready = 1'b0;
    else                      byte_ready = 1'b1;
    #1;
    if (byte_valid && byte_ready) got_q.push_back({byte_stat, byte_data});
  end

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] v);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) r = (r[0] ^ v[i]) ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    return r;
  endfunction

  task automatic raw_bit(input logic b);
    bit acc = 0;
    while (!acc) begin
      @(negedge clk); #2;
      ser_valid = 1'b1; ser_bit = b; acc = ser_ready;
      @(posedge clk);
    end
    #1;
    ser_valid = 1'b0;
    ga_last = go_ahead; idle_last = line_idle;
    if (go_ahead) ga_cnt++;
    if (($urandom % 5) == 0) @(negedge clk);
  endtask

  task automatic stuff_bit(input logic b);
    raw_bit(b);
    if (b) begin
      tx_ones++;
      if (tx_ones == 5) begin raw_bit(1'b0); tx_ones = 0; end
    end else tx_ones = 0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) stuff_bit(v[i]);
  endtask

  task automatic send_flag();
    logic [7:0] f = 8'h7E;
    for (int i = 0; i < 8; i++) raw_bit(f[i]);
    tx_ones = 0;
  endtask

  task automatic send_body(input int n, input bit bad);
    logic [15:0] c = 16'hFFFF;
    logic [15:0] fcs;
    for (int i = 0; i < n; i++) c = crc_upd(c, buf_b[i]);
    fcs = ~c;
    if (bad) fcs = fcs ^ 16'h0001;
    for (int i = 0; i < n; i++) send_byte(buf_b[i]);
    send_byte(fcs[7:0]);
    send_byte(fcs[15:8]);
    if (n >= 2)
      for (int i = 0; i < n; i++)
        exp_q.push_back({(i == 0) ? 2'b01 : (i == n - 1) ? (bad ? 2'b11 : 2'b10) : 2'b00, buf_b[i]});
  endtask

  task automatic compare_out(input string req);
    int m;
    ready_mode = 2;
    repeat (8) @(negedge clk);
    chk({req, " count"}, got_q.size(), exp_q.size());
    m = (got_q.size() < exp_q.size()) ? got_q.size() : exp_q.size();
    for (int i = 0; i < m; i++) chk({req, " byte"}, got_q[i], exp_q[i]);
    got_q.delete(); exp_q.delete();
    ready_mode = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
    $finish;
  end

  initial begin
    logic [9:0] held;
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #3;
    // R1 reset state
    chk("R1 byte_valid", byte_valid, 0);
    chk("R1 line_idle", line_idle, 0);
    chk("R1 go_ahead", go_ahead, 0);
    chk("R1 ser_ready", ser_ready, 1);
    rx_en = 1'b1;
    ready_mode = 0;

    // R2 hunt: stuffed random bytes, no flag
    for (int i = 0; i < 6; i++) send_byte(8'($urandom));
    compare_out("R2 hunt");

    // R3/R4/R5 good frame with stuffing-heavy bytes
    buf_b[0] = 8'h7E; buf_b[1] = 8'hFF; buf_b[2] = 8'h3C;
    send_flag(); send_body(3, 0); send_flag();
    compare_out("R3 R4 R5 good frame");

    // R6 bad FCS
    buf_b[0] = 8'hA5; buf_b[1] = 8'h01; buf_b[2] = 8'h80; buf_b[3] = 8'hC3;
    send_flag(); send_body(4, 1); send_flag();
    compare_out("R6 bad fcs");

    // R7 short frames
    send_flag(); send_body(0, 0); send_flag();
    buf_b[0] = 8'h55; send_body(1, 0); send_flag();
    compare_out("R7 short");

    // R5 shared flags between back-to-back frames
    send_flag();
    buf_b[0] = 8'h11; buf_b[1] = 8'h22; send_body(2, 0); send_flag();
    buf_b[0] = 8'h33; buf_b[1] = 8'h44; buf_b[2] = 8'hFE; send_body(3, 0); send_flag();
    compare_out("R5 shared flag");

    // R8 abort with trailing ones of last byte counted
    send_flag();
    for (int i = 0; i < 4; i++) begin buf_b[i] = 8'($urandom); send_byte(buf_b[i]); end
    send_byte(8'hE0);
    exp_q.push_back({2'b01, buf_b[0]});
    exp_q.push_back({2'b00, buf_b[1]});
    exp_q.push_back({2'b11, buf_b[2]});
    ready_mode = 2;
    for (int i = 0; i < 4; i++) raw_bit(1'b1);
    chk("R8 abort written on 4th one", {byte_valid, byte_stat}, 3'b111);
    compare_out("R8 abort");

    // R9 go-ahead
    send_flag();
    ga_cnt = 0;
    raw_bit(1'b0);
    for (int i = 0; i < 8; i++) raw_bit(1'b1);
    raw_bit(1'b0);
    chk("R9 eight ones", ga_cnt, 0);
    for (int i = 0; i < 7; i++) raw_bit(1'b1);
    raw_bit(1'b0);
    chk("R9 pulse after seven ones", ga_last, 1);
    for (int i = 0; i < 6; i++) raw_bit(1'b1);
    raw_bit(1'b0);
    chk("R9 single pulse total", ga_cnt, 1);
    compare_out("R9 no bytes");

    // R10 idle
    raw_bit(1'b0);
    for (int i = 0; i < 14; i++) raw_bit(1'b1);
    chk("R10 fourteen ones", idle_last, 0);
    raw_bit(1'b1);
    chk("R10 fifteen ones", idle_last, 1);
    raw_bit(1'b1);
    chk("R10 stays idle", idle_last, 1);
    raw_bit(1'b0);
    chk("R10 zero clears", idle_last, 0);

    // R12 disable clears idle and drops frame
    for (int i = 0; i < 15; i++) raw_bit(1'b1);
    rx_en = 1'b0;
    repeat (2) @(negedge clk); #3;
    chk("R12 idle cleared", line_idle, 0);
    rx_en = 1'b1;
    send_flag();
    for (int i = 0; i < 5; i++) begin buf_b[i] = 8'($urandom); send_byte(buf_b[i]); end
    exp_q.push_back({2'b01, buf_b[0]});
    exp_q.push_back({2'b00, buf_b[1]});
    rx_en = 1'b0;
    send_byte(8'h12); send_byte(8'h34); send_flag();
    rx_en = 1'b1;
    send_flag();
    compare_out("R12 disabled frame dropped");

    // R11 back-pressure
    for (int i = 0; i < 4; i++) buf_b[i] = 8'($urandom);
    ready_mode = 1;
    fork
      begin send_flag(); send_body(4, 0); send_flag(); end
      begin
        wait (byte_valid);
        @(negedge clk); #3;
        held = {byte_stat, byte_data};
        repeat (30) @(negedge clk);
        #3;
        chk("R11 valid held", byte_valid, 1);
        chk("R11 data stable", {byte_stat, byte_data}, held);
        chk("R11 first byte", held, {2'b01, buf_b[0]});
        chk("R11 input stalled", ser_ready, 0);
        ready_mode = 0;
      end
    join
    compare_out("R11 after stall");

    // random frames
    send_flag();
    for (int it = 0; it < 40; it++) begin
      int n;
      bit bad;
      if (($urandom % 3) == 0) begin
        int k = $urandom % 21;
        for (int j = 0; j < k; j++) raw_bit(1'b1);
        send_flag();
      end
      n = $urandom % 7;
      bad = (($urandom % 4) == 0);
      for (int j = 0; j < n; j++) buf_b[j] = 8'($urandom);
      send_body(n, bad);
      send_flag();
    end
    compare_out("R4 R5 R6 R7 random");

    report();
    $finish;
  end
endmodule